// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects four interrupt sources for a small CPU core: a falling edge on an external pin, a timer overflow pulse, a USB event pulse and an SPI byte-done pulse. Each source has a request flag and an enable bit, and one global enable gates all of them. When the global enable is set, at least one enabled flag is pending and the return-address stack has room, the block accepts the highest-priority request. It then pulses a push strobe to the core, presents that source's vector as the next fetch address, clears the accepted flag and clears the global enable.

Software reaches the flags, the enables and the global enable through a three-register interface. A service routine may set the global enable again to allow a nested interrupt. A return strobe from the core is answered with a pop strobe one cycle later.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Flag bits and enable bits share one bit order: bit 0 external, bit 1 USB, bit 2 timer, bit 3 SPI. Enables are at register address 1 and flags at address 2. A single-cycle pulse on a source input sets its flag on the next clock edge only if its enable bit is set.
- R2: The external pin passes through a two-stage synchronizer. A falling edge sets flag bit 0 on the third rising clock edge after the pin falls. A rising edge sets no flag.
- R3: The global enable is bit 0 of register address 0. While it is 0, nothing is accepted, but enabled requests are still recorded in their flags.
- R4: A request is accepted on a clock edge where the global enable is 1, (flags AND enables) is nonzero and stack_full_i is low. push_o is high for exactly the cycle after that edge, and vector_o holds the vector from that cycle on.
- R5: Among pending enabled requests, priority is external, then USB, then timer, then SPI. The vectors are 0x04, 0x08, 0x0C and 0x10 in that same order.
- R6: On acceptance, the global enable and the accepted source's flag are cleared. All other flags are kept.
- R7: While stack_full_i is high, no request is accepted. Acceptance follows on the first clock edge after it drops.
- R8: A one-cycle reti_i pulse produces a one-cycle pop_o pulse in the following cycle.
- R9: If software sets the global enable during a service routine while another enabled flag is pending, a second acceptance follows.
- R10: After reset, all registers read 0 and push_o, pop_o and vector_o are 0.
- R11: A write to address 2 overwrites the flags with the written value, so software can clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous, active on falling edge |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| usb_evt_i | input | 1 | USB event pulse |
| spi_done_i | input | 1 | SPI byte-complete pulse |
| stack_full_i | input | 1 | Return-address stack is full |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 enables, 2 flags) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on reg_addr_i |
| push_o | output | 1 | Push return address strobe |
| pop_o | output | 1 | Pop return address strobe |
| vector_o | output | 8 | Vector of the last accepted source |

## Verification
The bench builds the block with its default parameters: an 8-bit register interface, an 8-bit vector, a two-stage pin synchronizer, and vectors based at 0x04 with a step of 4. The short synchronizer puts the exact edge on which the external flag is set within reach of a few-cycle check. The 8-bit vector width shows all four vector values unchanged. A table walks the priority order over mixed flag and enable patterns, including a masked top source and a stack-full case. Directed tests then cover the synchronizer latency, gated pulses, stack-full release, nesting and the return handshake.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 4;
  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_USB = 2'd1,
    SRC_TMR = 2'd2,
    SRC_SPI = 2'd3
  } src_e;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_EN   = 2'd1;
  localparam logic [1:0] REG_FLAG = 2'd2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Idle level is high, so reset to 1 to avoid a false edge.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= pin_i;
        else sync_q[s] <= sync_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else last_q <= sync_q[STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  a_r2_fall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_data_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;

  // Software write first, then acceptance clear, then a new event wins.
  always_comb begin
    flags_d = sw_we_i ? sw_data_i : flags_q;
    flags_d = flags_d & ~clr_i;
    flags_d = flags_d | (set_i & en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r1_gated_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && !flags_q[0] && !(set_i[0] && en_i[0])) |=> !flags_q[0]);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N        = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic             any_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [IDX_W-1:0] idx;

  // Lowest index has highest priority.
  always_comb begin
    idx     = '0;
    grant_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx     = IDX_W'(i);
        grant_o = N'(1) << i;
      end
    end
  end

  assign any_o    = |req_i;
  assign vector_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx);

  always_comb begin
    a_r5_grant_onehot: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic              tmr_ovf_i,
  input  logic              usb_evt_i,
  input  logic              spi_done_i,
  input  logic              stack_full_i,
  input  logic              reti_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [VEC_W-1:0]  vector_o
);
  import irq_pkg::*;

  logic            ext_fall;
  logic [NSRC-1:0] src_set, en_q, flags, pend, grant;
  logic            gie_q, any_pend, accept;
  logic [VEC_W-1:0] arb_vec;

  irq_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(ext_pin_i), .fall_o(ext_fall)
  );

  always_comb begin
    src_set          = '0;
    src_set[SRC_EXT] = ext_fall;
    src_set[SRC_USB] = usb_evt_i;
    src_set[SRC_TMR] = tmr_ovf_i;
    src_set[SRC_SPI] = spi_done_i;
  end

  assign pend   = flags & en_q;
  assign accept = gie_q & any_pend & ~stack_full_i;

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (src_set),
    .en_i     (en_q),
    .clr_i    (accept ? grant : '0),
    .sw_we_i  (reg_we_i && reg_addr_i == REG_FLAG),
    .sw_data_i(reg_wdata_i[NSRC-1:0]),
    .flags_o  (flags)
  );

  irq_prio_arb #(.N(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req_i   (pend),
    .grant_o (grant),
    .any_o   (any_pend),
    .vector_o(arb_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      gie_q    <= 1'b0;
      push_o   <= 1'b0;
      pop_o    <= 1'b0;
      vector_o <= '0;
    end else begin
      push_o <= accept;
      pop_o  <= reti_i;
      if (reg_we_i && reg_addr_i == REG_EN) en_q <= reg_wdata_i[NSRC-1:0];
      // Hardware clear on acceptance wins over a same-cycle write.
      if (accept) begin
        gie_q    <= 1'b0;
        vector_o <= arb_vec;
      end else if (reg_we_i && reg_addr_i == REG_CTRL) begin
        gie_q <= reg_wdata_i[0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL: reg_rdata_o[0]        = gie_q;
      REG_EN:   reg_rdata_o[NSRC-1:0] = en_q;
      REG_FLAG: reg_rdata_o[NSRC-1:0] = flags;
      default:  reg_rdata_o           = '0;
    endcase
  end

  a_r3_push_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> $past(gie_q));
  a_r4_push_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  a_r6_gie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !gie_q);
  a_r7_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> !$past(stack_full_i));
  a_r8_pop_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pop_o) |-> $past(reti_i));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ext_pin = 1'b1, tmr = 1'b0, usb = 1'b0, spi = 1'b0;
  logic       sfull = 1'b0, reti = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata, vec;
  logic       push, pop;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr),
    .usb_evt_i(usb), .spi_done_i(spi), .stack_full_i(sfull), .reti_i(reti),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .push_o(push), .pop_o(pop), .vector_o(vec)
  );

  // {en[3:0], flags[3:0], stack_full, exp_push, exp_vec[7:0], exp_flags_after[3:0]}
  localparam logic [21:0] TBL [8] = '{
    {4'hF, 4'h1, 1'b0, 1'b1, 8'h04, 4'h0},
    {4'hF, 4'h6, 1'b0, 1'b1, 8'h08, 4'h4},
    {4'hF, 4'hC, 1'b0, 1'b1, 8'h0C, 4'h8},
    {4'hF, 4'h8, 1'b0, 1'b1, 8'h10, 4'h0},
    {4'hF, 4'hF, 1'b1, 1'b0, 8'h00, 4'hF},
    {4'hE, 4'hF, 1'b0, 1'b1, 8'h08, 4'hD},
    {4'h0, 4'hF, 1'b0, 1'b0, 8'h00, 4'hF},
    {4'h8, 4'h9, 1'b0, 1'b1, 8'h10, 4'h1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd(2'd0, r); check("R10 ctrl", r, 0);
    rd(2'd1, r); check("R10 en", r, 0);
    rd(2'd2, r); check("R10 flags", r, 0);
    check("R10 push", push, 0);
    check("R10 pop", pop, 0);
    check("R10 vector", vec, 0);

    // Table: priority, vectors, masking, stack full
    for (int k = 0; k < 8; k++) begin
      logic [21:0] e;
      e = TBL[k];
      wr(2'd0, 8'h00);
      sfull = 1'b0;
      wr(2'd1, {4'h0, e[21:18]});
      wr(2'd2, {4'h0, e[17:14]});
      sfull = e[13];
      wr(2'd0, 8'h01);
      step();
      check($sformatf("R4 push entry %0d", k), push, e[12]);
      if (e[12]) begin
        check($sformatf("R5 vector entry %0d", k), vec, e[11:4]);
        rd(2'd0, r); check($sformatf("R6 gie cleared entry %0d", k), r, 0);
      end else if (e[13]) begin
        check($sformatf("R7 blocked entry %0d", k), push, 0);
      end
      rd(2'd2, r); check($sformatf("R6 flags after entry %0d", k), r, {4'h0, e[3:0]});
    end
    wr(2'd0, 8'h00);
    sfull = 1'b0;

    // R11 software clear, R1 gated pulses, R3 record while gie off
    wr(2'd2, 8'h00);
    rd(2'd2, r); check("R11 flags cleared", r, 0);
    wr(2'd1, 8'h04);
    @(negedge clk); tmr = 1'b1; spi = 1'b1;
    @(negedge clk); tmr = 1'b0; spi = 1'b0;
    rd(2'd2, r); check("R1 enabled tmr set, spi masked", r, 8'h04);
    check("R3 no accept with gie off", push, 0);
    @(negedge clk); usb = 1'b1;
    @(negedge clk); usb = 1'b0;
    rd(2'd2, r); check("R1 usb masked", r, 8'h04);

    // R2 external falling edge latency
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h01);
    ext_pin = 1'b0;
    step(); step();
    rd(2'd2, r); check("R2 not yet after 2 edges", r, 0);
    step();
    rd(2'd2, r); check("R2 set on 3rd edge", r, 8'h01);
    wr(2'd2, 8'h00);
    ext_pin = 1'b1;
    repeat (4) step();
    rd(2'd2, r); check("R2 rising edge ignored", r, 0);

    // R7 stack full hold-off and release
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h02);
    sfull = 1'b1;
    wr(2'd0, 8'h01);
    step(); check("R7 held while full", push, 0);
    step(); check("R7 still held", push, 0);
    sfull = 1'b0;
    step();
    check("R7 push after release", push, 1);
    check("R7 vector after release", vec, 8'h08);

    // R9 nesting
    wr(2'd2, 8'h01);
    step(); check("R9 no accept before gie set", push, 0);
    wr(2'd0, 8'h01);
    step();
    check("R9 nested push", push, 1);
    check("R9 nested vector", vec, 8'h04);

    // R8 return handshake
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
    check("R8 pop pulse", pop, 1);
    step();
    check("R8 pop single", pop, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule